// File: doc/BRIEF.md
# Grouped Interrupt Request Controller

This block gathers event pulses from peripheral sources and presents a single vectored interrupt request to a processor core. Sources come in two kinds. Grouped sources sit in one of up to seven shared groups, and each group owns one vector. A solo source owns a vector of its own. As an example of the mapping, a PWM unit's period match and its first three duty matches can share one group, while its fourth duty match takes a solo vector.

Flags are kept on two levels. Each grouped source has a member flag, which is set by its event and is cleared only by a software clear strobe. Each vector has a vector flag, which the arbiter examines. When the core acknowledges service, hardware clears the served vector flag and the global enable. Member flags inside the group are left unchanged. A return-from-interrupt strobe sets the global enable again.

All pins are plain control and status signals. No streaming data crosses the edge of the block, so no valid/ready handshake is used. The request output is combinational from the flag registers. An acknowledge takes effect at the clock edge where it is sampled.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, all member flags, all vector flags and the global enable are 0, and `irq_req` is 0.
- R2: An event pulse on a grouped source sets its member flag at the next clock edge, whatever the enables are. The flag stays set until a clear strobe on the same bit. If an event and a clear arrive in the same cycle, the event wins. Source bit index = group*SRC_PER_GRP + member.
- R3: A group's vector flag is set one cycle after the cycle in which an enabled member flag (member flag AND member enable) first becomes 1. A member whose enable is 0 never sets the group flag.
- R4: A serviced group clears its vector flag and the global enable at the acknowledge edge. The member flags of that group do not change.
- R5: A member flag that remains set after its group flag has been cleared does not set the group flag again.
- R6: A solo event sets its vector flag at the next clock edge. A solo source has no member flag. Servicing clears the solo vector flag.
- R7: `irq_req` is 1 only when the global enable is 1, `stack_full` is 0, and at least one vector has both its flag and its vector enable set.
- R8: Among requesting vectors, the lowest vector number wins. Group g is vector g, and solo k is vector N_GROUPS+k.
- R9: `reti` sets the global enable to 1. `gie_wr` loads `gie_wdata`. Events that arrive while the global enable is 0 are still latched, and they request once the enable returns.
- R10: `svc_ack` has no effect when `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | N_GROUPS*SRC_PER_GRP | Grouped source event pulses |
| src_en | input | N_GROUPS*SRC_PER_GRP | Per-source enables |
| src_clr | input | N_GROUPS*SRC_PER_GRP | Software member-flag clear strobes |
| solo_evt | input | N_SOLO | Solo source event pulses |
| vec_en | input | N_GROUPS+N_SOLO | Per-vector enables |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| stack_full | input | 1 | Core stack has no room |
| svc_ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to core |
| irq_vec | output | clog2(N_GROUPS+N_SOLO) | Vector number presented |
| src_flags | output | N_GROUPS*SRC_PER_GRP | Member flags |
| vec_flags | output | N_GROUPS+N_SOLO | Vector flags |
| gie | output | 1 | Global enable state |

## Verification
The bench builds the block with two groups of two members and one solo source, which gives three vectors. At this size the bench sweeps every combination of pending vectors, vector enables and stack-full state, and it compares the winner against the lowest set bit of the masked pending word. The small member count also lets directed sequences cover set-versus-clear ordering, a disabled member, a member flag that outlives its group flag, events latched while the global enable is 0, and an acknowledge given while no request is present.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_MAX_GROUPS = 7;

  function automatic int unsigned irq_vec_width(input int unsigned n_vec);
    return (n_vec < 2) ? 1 : $clog2(n_vec);
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] flag,
  output logic [N_SRC-1:0] mreq,
  output logic [N_SRC-1:0] rise
);
  logic [N_SRC-1:0] mreq_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= '0;
      mreq_prev <= '0;
    end else begin
      flag      <= evt | (flag & ~clr);
      mreq_prev <= mreq;
    end
  end

  assign mreq = flag & en;
  assign rise = mreq & ~mreq_prev;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_chk
      // R2: a member flag holds unless a clear strobe arrives
      a_r2_member_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !clr[i]) |=> flag[i]);
      // R2: an event always lands in the member flag
      a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_vec_flags.sv
module irq_vec_flags #(
  parameter int unsigned N_GROUPS    = 7,
  parameter int unsigned SRC_PER_GRP = 4,
  parameter int unsigned N_SOLO      = 1,
  localparam int unsigned N_SRC      = N_GROUPS * SRC_PER_GRP,
  localparam int unsigned N_VEC      = N_GROUPS + N_SOLO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  rise,
  input  logic [N_SRC-1:0]  mreq,
  input  logic [N_SOLO-1:0] solo_evt,
  input  logic [N_VEC-1:0]  clr_vec,
  output logic [N_VEC-1:0]  vflag
);
  genvar g, k;
  generate
    for (g = 0; g < N_GROUPS; g++) begin : g_grp
      logic set_g;
      assign set_g = |rise[g*SRC_PER_GRP +: SRC_PER_GRP];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vflag[g] <= 1'b0;
        else        vflag[g] <= set_g | (vflag[g] & ~clr_vec[g]);
      end
      // R3: a group flag only rises after an enabled member request
      a_r3_group_has_member: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vflag[g]) |-> $past(|mreq[g*SRC_PER_GRP +: SRC_PER_GRP]));
      // R4: a served group flag drops unless a fresh member edge arrives
      a_r4_group_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[g] && !set_g) |=> !vflag[g]);
    end
    for (k = 0; k < N_SOLO; k++) begin : g_solo
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vflag[N_GROUPS+k] <= 1'b0;
        else        vflag[N_GROUPS+k] <= solo_evt[k] | (vflag[N_GROUPS+k] & ~clr_vec[N_GROUPS+k]);
      end
      // R6: a solo event always sets its vector flag
      a_r6_solo_set: assert property (@(posedge clk) disable iff (!rst_n)
        solo_evt[k] |=> vflag[N_GROUPS+k]);
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_VEC = 8,
  localparam int unsigned VEC_W = irq_pkg::irq_vec_width(N_VEC)
) (
  input  logic [N_VEC-1:0] pend,
  output logic             any,
  output logic [VEC_W-1:0] idx,
  output logic [N_VEC-1:0] grant
);
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (pend[i]) idx = VEC_W'(i);
    end
    any = |pend;
    if (any) grant[idx] = 1'b1;
  end

  // R8: at most one winner, and it is pending
  always_comb begin
    a_r8_onehot_grant: assert ($onehot0(grant));
    a_r8_grant_pending: assert ((grant & ~pend) == '0);
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int unsigned N_GROUPS    = 7,
  parameter int unsigned SRC_PER_GRP = 4,
  parameter int unsigned N_SOLO      = 1,
  localparam int unsigned N_SRC      = N_GROUPS * SRC_PER_GRP,
  localparam int unsigned N_VEC      = N_GROUPS + N_SOLO,
  localparam int unsigned VEC_W      = irq_pkg::irq_vec_width(N_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [N_SRC-1:0]  src_clr,
  input  logic [N_SOLO-1:0] solo_evt,
  input  logic [N_VEC-1:0]  vec_en,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic              stack_full,
  input  logic              svc_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [N_SRC-1:0]  src_flags,
  output logic [N_VEC-1:0]  vec_flags,
  output logic              gie
);
  logic [N_SRC-1:0] mreq, rise;
  logic [N_VEC-1:0] pend, grant, clr_vec;
  logic             any_pend, svc_fire, gie_q;

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .en(src_en), .clr(src_clr),
    .flag(src_flags), .mreq(mreq), .rise(rise)
  );

  irq_vec_flags #(.N_GROUPS(N_GROUPS), .SRC_PER_GRP(SRC_PER_GRP), .N_SOLO(N_SOLO)) u_vflags (
    .clk(clk), .rst_n(rst_n), .rise(rise), .mreq(mreq), .solo_evt(solo_evt),
    .clr_vec(clr_vec), .vflag(vec_flags)
  );

  assign pend = vec_flags & vec_en;

  irq_arbiter #(.N_VEC(N_VEC)) u_arb (
    .pend(pend), .any(any_pend), .idx(irq_vec), .grant(grant)
  );

  assign irq_req  = any_pend & gie_q & ~stack_full;
  assign svc_fire = svc_ack & irq_req;
  assign clr_vec  = svc_fire ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gie_q <= 1'b0;
    else if (svc_fire) gie_q <= 1'b0;
    else if (reti)     gie_q <= 1'b1;
    else if (gie_wr)   gie_q <= gie_wdata;
  end
  assign gie = gie_q;

  initial begin
    a_cfg_groups: assert (N_GROUPS >= 1 && N_GROUPS <= irq_pkg::IRQ_MAX_GROUPS);
  end

  // R7: a request needs the global enable and stack room
  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && !stack_full && vec_en[irq_vec] && vec_flags[irq_vec]));
  // R4: service drops the global enable
  a_r4_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> !gie);
  // R9: return from interrupt restores the global enable
  a_r9_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !svc_fire) |=> gie);
  // R10: an acknowledge without a request leaves the vector flags alone
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !irq_req && (src_evt == '0) && (solo_evt == '0)) |=> $stable(vec_flags));
  // R4: service never touches member flags
  a_r4_members_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_fire && (src_clr == '0)) |=> ((src_flags & $past(src_flags)) == $past(src_flags)));
endmodule

// File: tb/irq_group_ctrl_tb_top.sv
module irq_group_ctrl_tb_top;
  localparam int G = 2, S = 2, K = 1, NS = G*S, NV = G+K, VW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_evt = '0, src_en = '0, src_clr = '0;
  logic [K-1:0]  solo_evt = '0;
  logic [NV-1:0] vec_en = '0;
  logic gie_wr = 0, gie_wdata = 0, stack_full = 0, svc_ack = 0, reti = 0;
  logic irq_req, gie;
  logic [VW-1:0] irq_vec;
  logic [NS-1:0] src_flags;
  logic [NV-1:0] vec_flags;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_group_ctrl #(.N_GROUPS(G), .SRC_PER_GRP(S), .N_SOLO(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en), .src_clr(src_clr),
    .solo_evt(solo_evt), .vec_en(vec_en), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
    .stack_full(stack_full), .svc_ack(svc_ack), .reti(reti), .irq_req(irq_req),
    .irq_vec(irq_vec), .src_flags(src_flags), .vec_flags(vec_flags), .gie(gie)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_src(input int i);
    src_evt[i] = 1'b1; tick(); src_evt = '0;
  endtask

  task automatic do_reti(); reti = 1; tick(); reti = 0; endtask
  task automatic do_ack();  svc_ack = 1; tick(); svc_ack = 0; endtask

  task automatic drain();
    vec_en = '1; stack_full = 0;
    for (int n = 0; n < 8; n++) begin
      if (irq_req) begin do_ack(); do_reti(); end
    end
    src_clr = '1; tick(); src_clr = '0; tick();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 irq_req", irq_req, 0);
    check("R1 flags", {src_flags, vec_flags}, 0);
    check("R1 gie", gie, 0);

    gie_wr = 1; gie_wdata = 1; tick(); gie_wr = 0;
    check("R9 gie write", gie, 1);
    src_en = '1; vec_en = '1;

    // R2/R3: member 1 of group 0
    pulse_src(1);
    check("R2 member set", src_flags, 4'b0010);
    check("R3 group latency", vec_flags[0], 0);
    tick();
    check("R3 group set", vec_flags, 3'b001);
    check("R8 req vec0", {irq_req, irq_vec}, {1'b1, 2'd0});

    // R4 service
    do_ack();
    check("R4 group cleared", vec_flags, 0);
    check("R4 gie cleared", gie, 0);
    check("R4 member kept", src_flags, 4'b0010);

    // R5 no re-set from lingering member
    do_reti(); tick(); tick(); tick();
    check("R5 no reassert", vec_flags, 0);
    check("R5 no req", irq_req, 0);

    // R2 software clear, and set wins over clear
    src_clr[1] = 1; tick(); src_clr = '0;
    check("R2 clear", src_flags, 0);
    src_evt[0] = 1; src_clr[0] = 1; tick(); src_evt = '0; src_clr = '0;
    check("R2 set wins", src_flags[0], 1);
    tick(); drain();

    // R3 disabled member does not set its group
    src_en[2] = 0; pulse_src(2); tick(); tick();
    check("R3 disabled member flag", src_flags[2], 1);
    check("R3 disabled no group", vec_flags[1], 0);
    src_clr[2] = 1; tick(); src_clr = '0; src_en = '1; tick();

    // R9 latch while gie off; R6 solo one-cycle
    gie_wr = 1; gie_wdata = 0; tick(); gie_wr = 0;
    solo_evt = 1; tick(); solo_evt = 0;
    check("R6 solo set", vec_flags, 3'b100);
    check("R9 held off", irq_req, 0);
    do_reti();
    check("R9 req after reti", {irq_req, irq_vec}, {1'b1, 2'd2});

    // R7 stack full blocks
    stack_full = 1; tick();
    check("R7 stack full", irq_req, 0);
    stack_full = 0;

    // R10 ack without request
    vec_en[2] = 0; do_ack();
    check("R10 flag kept", vec_flags[2], 1);
    check("R10 gie kept", gie, 1);
    vec_en = '1; do_ack();
    check("R6 solo serviced", vec_flags[2], 0);
    do_reti(); drain();

    // R7/R8 sweep
    for (int sf = 0; sf < 2; sf++) begin
      for (int p = 1; p < 8; p++) begin
        for (int e = 0; e < 8; e++) begin
          int m, lo;
          vec_en = 3'(e);
          src_evt[0] = p[0]; src_evt[2] = p[1]; solo_evt[0] = p[2];
          tick(); src_evt = '0; solo_evt = '0; tick();
          stack_full = sf[0]; tick();
          m = p & e; lo = 0;
          for (int b = 2; b >= 0; b--) if (m[b]) lo = b;
          check("R7 sweep req", irq_req, (m != 0 && sf == 0) ? 1 : 0);
          if (m != 0 && sf == 0) check("R8 sweep vec", irq_vec, lo);
          drain();
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule